// File: doc/BRIEF.md
# Stereo Serial-to-Parallel Sample Receiver

This block takes two serial sample streams, one for the left channel and one for the right, from an oversampling converter. Both streams share one input bit clock. Each stream is shifted into its own serial-to-parallel register, MSB first. When the convert strobe reaches its capture edge, the completed words of both channels move together into parallel holding registers. A one-cycle valid pulse marks each captured pair.

A mode input selects 18-bit or 16-bit words. The capture edge depends on the mode: the rising edge of the strobe captures in 18-bit mode, and the falling edge captures in 16-bit mode. The bit clock, the strobe, the mode and both data lines are sampled and edge-detected in the system clock domain. None of them is used as a clock. Only the most recent 16 or 18 bits before the capture edge are kept. Any earlier or invalid bits simply fall out of the shift register. A 16-bit word is sign-extended to the full output width.

Top module: `stereo_sipo_rx`

## Requirements
- R1: While reset is asserted, both sample outputs are zero and the valid output is low.
- R2: With the mode input high (18-bit mode), a rising edge of the convert strobe captures the last 18 bits shifted in. The first bit shifted becomes output bit 17 (MSB first, two's complement).
- R3: With the mode input low (16-bit mode), a falling edge of the convert strobe captures the last 16 bits shifted in. These bits appear on output bits 15..0, and bits 17..16 repeat bit 15.
- R4: The strobe edge that does not belong to the current mode captures nothing. The outputs keep their values and no valid pulse appears.
- R5: Extra bit-clock rising edges that come before the MSB of a word do not affect the captured word.
- R6: Left and right words are shifted on the same bit-clock edges and captured on the same strobe edge, each from its own data input.
- R7: Each capture produces a valid pulse exactly one system-clock cycle long, in the same cycle the new samples appear.
- R8: Between captures the sample outputs hold their values, even while more bits are being shifted in.
- R9: A data line is sampled only at the rising edge of the bit clock. A change of the data line while the bit clock is high has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk_i | input | 1 | Shared serial bit clock (sampled, not used as a clock) |
| data_l_i | input | 1 | Left-channel serial data |
| data_r_i | input | 1 | Right-channel serial data |
| conv_i | input | 1 | Convert strobe that marks word completion |
| wide_mode_i | input | 1 | 1 = 18-bit words, capture on strobe rise; 0 = 16-bit words, capture on strobe fall |
| sample_l_o | output | WIDE_W | Captured left sample, sign-extended |
| sample_r_o | output | WIDE_W | Captured right sample, sign-extended |
| valid_o | output | 1 | One-cycle pulse for each captured pair |

## Verification
The assertions check on every cycle the following properties:
- the reset state;
- that the valid pulse never lasts two cycles;
- that the outputs change only together with a valid pulse;
- that each capture follows a strobe transition of the polarity set by the mode;
- that 16-bit captures carry a correct sign extension.

Some behaviour can only be shown by the bench's scenarios, because it needs a known serial word as a reference:
- the bit order of the captured word;
- that leading invalid bits are discarded;
- that data changes during the high phase of the bit clock are ignored;
- that the two channels stay independent.

// File: rtl/stsipo_pkg.sv
package stsipo_pkg;
   // Number of channels sharing the bit clock and strobe
   localparam int NUM_CH   = 2;
   // Positions of the control lines in the synchronizer vector
   localparam int IDX_BCK  = 0;
   localparam int IDX_CONV = 1;
   localparam int IDX_MODE = 2;
   // Data lines follow the control lines, one per channel
   localparam int CH_BASE  = 3;
   localparam int CH_LEFT  = 0;
   localparam int CH_RIGHT = 1;
endpackage

// File: rtl/stsipo_sync.sv
module stsipo_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("stsipo_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= async_i;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/stsipo_edge.sv
module stsipo_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   input  logic pick_fall_i,
   output logic pulse_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level_i;
   end

   // A transition whose new level matches the wanted polarity
   assign pulse_o = (level_i != prev_q) && (level_i == !pick_fall_i);
endmodule

// File: rtl/stsipo_shift.sv
module stsipo_shift #(
   parameter int WIDTH = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_i,
   input  logic             bit_i,
   output logic [WIDTH-1:0] word_o
);
   if (WIDTH < 2) begin : g_bad_width
      $error("stsipo_shift: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sr_q <= '0;
      else if (shift_i) sr_q <= {sr_q[WIDTH-2:0], bit_i};
   end

   assign word_o = sr_q;
endmodule

// File: rtl/stsipo_hold.sv
module stsipo_hold #(
   parameter int WIDE_W   = 18,
   parameter int NARROW_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic              narrow_i,
   input  logic [WIDE_W-1:0] word_i,
   output logic [WIDE_W-1:0] sample_o
);
   localparam int EXT_W = WIDE_W - NARROW_W;

   if (EXT_W < 1) begin : g_bad_ext
      $error("stsipo_hold: NARROW_W must be below WIDE_W");
   end

   logic [WIDE_W-1:0] narrow_word;
   logic [WIDE_W-1:0] sample_q;

   assign narrow_word = {{EXT_W{word_i[NARROW_W-1]}}, word_i[NARROW_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sample_q <= '0;
      else if (cap_i) sample_q <= narrow_i ? narrow_word : word_i;
   end

   assign sample_o = sample_q;
endmodule

// File: rtl/stereo_sipo_rx.sv
module stereo_sipo_rx
   import stsipo_pkg::*;
#(
   parameter int WIDE_W      = 18,
   parameter int NARROW_W    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_clk_i,
   input  logic              data_l_i,
   input  logic              data_r_i,
   input  logic              conv_i,
   input  logic              wide_mode_i,
   output logic [WIDE_W-1:0] sample_l_o,
   output logic [WIDE_W-1:0] sample_r_o,
   output logic              valid_o
);
   localparam int SYNC_W = CH_BASE + NUM_CH;

   if (NARROW_W < 2 || NARROW_W >= WIDE_W) begin : g_bad_widths
      $error("stereo_sipo_rx: need 2 <= NARROW_W < WIDE_W");
   end

   logic [SYNC_W-1:0] raw_in;
   logic [SYNC_W-1:0] synced;
   logic              bit_s;
   logic              conv_s;
   logic              mode_s;
   logic              shift_pulse;
   logic              cap_pulse;
   logic [WIDE_W-1:0] sample_arr [NUM_CH];

   assign raw_in[IDX_BCK]           = bit_clk_i;
   assign raw_in[IDX_CONV]          = conv_i;
   assign raw_in[IDX_MODE]          = wide_mode_i;
   assign raw_in[CH_BASE+CH_LEFT]   = data_l_i;
   assign raw_in[CH_BASE+CH_RIGHT]  = data_r_i;

   stsipo_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (raw_in),
      .sync_o  (synced)
   );

   assign bit_s  = synced[IDX_BCK];
   assign conv_s = synced[IDX_CONV];
   assign mode_s = synced[IDX_MODE];

   // Bits shift on the bit-clock rise only
   stsipo_edge i_bit_edge (
      .clk         (clk),
      .rst_n       (rst_n),
      .level_i     (bit_s),
      .pick_fall_i (1'b0),
      .pulse_o     (shift_pulse)
   );

   // Capture polarity follows the word-length mode
   stsipo_edge i_conv_edge (
      .clk         (clk),
      .rst_n       (rst_n),
      .level_i     (conv_s),
      .pick_fall_i (!mode_s),
      .pulse_o     (cap_pulse)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic [WIDE_W-1:0] word;

      stsipo_shift #(.WIDTH(WIDE_W)) i_shift (
         .clk     (clk),
         .rst_n   (rst_n),
         .shift_i (shift_pulse),
         .bit_i   (synced[CH_BASE+ch]),
         .word_o  (word)
      );

      stsipo_hold #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) i_hold (
         .clk      (clk),
         .rst_n    (rst_n),
         .cap_i    (cap_pulse),
         .narrow_i (!mode_s),
         .word_i   (word),
         .sample_o (sample_arr[ch])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_o <= 1'b0;
      else        valid_o <= cap_pulse;
   end

   assign sample_l_o = sample_arr[CH_LEFT];
   assign sample_r_o = sample_arr[CH_RIGHT];
endmodule

// File: rtl/stereo_sipo_rx_chk.sv
module stereo_sipo_rx_chk #(
   parameter int WIDE_W   = 18,
   parameter int NARROW_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              conv_s,
   input logic              mode_s,
   input logic [WIDE_W-1:0] sample_l_o,
   input logic [WIDE_W-1:0] sample_r_o,
   input logic              valid_o
);
   always @(negedge clk) begin
      if (!rst_n) begin
         assert_reset_state_R1: assert (!valid_o && sample_l_o == '0 && sample_r_o == '0)
            else $error("reset state violated");
      end
   end

   assert_capture_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> ($past(conv_s, 1) != $past(conv_s, 2)) && ($past(conv_s, 1) == $past(mode_s, 1)));

   assert_sign_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !$past(mode_s, 1)) |->
         (sample_l_o[WIDE_W-1:NARROW_W] == {(WIDE_W-NARROW_W){sample_l_o[NARROW_W-1]}}) &&
         (sample_r_o[WIDE_W-1:NARROW_W] == {(WIDE_W-NARROW_W){sample_r_o[NARROW_W-1]}}));

   assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((sample_l_o != $past(sample_l_o)) || (sample_r_o != $past(sample_r_o))) |-> valid_o);
endmodule

bind stereo_sipo_rx stereo_sipo_rx_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .conv_s     (conv_s),
   .mode_s     (mode_s),
   .sample_l_o (sample_l_o),
   .sample_r_o (sample_r_o),
   .valid_o    (valid_o)
);

// File: tb/test_stereo_sipo_rx.sv
`timescale 1ns/1ps
module test_stereo_sipo_rx;
   localparam int W = 18;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bck = 1'b0;
   logic         dl = 1'b0;
   logic         dr = 1'b0;
   logic         conv = 1'b0;
   logic         wide = 1'b1;
   logic [W-1:0] sl;
   logic [W-1:0] sr;
   logic         valid;

   int tests = 0;
   int fails = 0;
   int vcount = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   stereo_sipo_rx i_stereo_sipo_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_clk_i   (bck),
      .data_l_i    (dl),
      .data_r_i    (dr),
      .conv_i      (conv),
      .wide_mode_i (wide),
      .sample_l_o  (sl),
      .sample_r_o  (sr),
      .valid_o     (valid)
   );

   always @(posedge clk) if (valid) vcount++;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One bit; the data line flips while the bit clock is high (R9)
   task automatic send_bit(input logic bl, input logic br);
      @(negedge clk); dl = bl; dr = br; bck = 1'b0;
      repeat (3) @(negedge clk);
      bck = 1'b1;
      repeat (2) @(negedge clk);
      dl = ~bl; dr = ~br;
      repeat (2) @(negedge clk);
   endtask

   task automatic send_word(input int n, input logic [W-1:0] l, input logic [W-1:0] r);
      for (int i = n - 1; i >= 0; i--) send_bit(l[i], r[i]);
   endtask

   task automatic set_conv(input logic v);
      @(negedge clk); conv = v;
      repeat (8) @(negedge clk);
   endtask

   task automatic t_reset;
      check("R1 left at reset", 32'(sl), 32'h0);
      check("R1 right at reset", 32'(sr), 32'h0);
      check("R1 valid at reset", 32'(valid), 32'h0);
   endtask

   task automatic t_wide;
      int c0;
      wide = 1'b1;
      repeat (4) @(negedge clk);
      send_word(18, 18'h2A5C3, 18'h15A3C);
      c0 = vcount;
      set_conv(1'b1);
      check("R2 R9 wide left", 32'(sl), 32'h2A5C3);
      check("R6 wide right", 32'(sr), 32'h15A3C);
      check("R7 one pulse", 32'(vcount - c0), 32'd1);
      set_conv(1'b0);
      check("R4 wide fall ignored left", 32'(sl), 32'h2A5C3);
      check("R4 wide fall no pulse", 32'(vcount - c0), 32'd1);
   endtask

   task automatic t_lead;
      int c0;
      send_bit(1'b1, 1'b0);
      send_bit(1'b0, 1'b1);
      send_bit(1'b1, 1'b1);
      send_word(18, 18'h30001, 18'h0FFFE);
      c0 = vcount;
      set_conv(1'b1);
      check("R5 lead bits left", 32'(sl), 32'h30001);
      check("R5 lead bits right", 32'(sr), 32'h0FFFE);
      check("R7 pulse after lead", 32'(vcount - c0), 32'd1);
      set_conv(1'b0);
   endtask

   task automatic t_narrow;
      int c0;
      wide = 1'b0;
      repeat (4) @(negedge clk);
      c0 = vcount;
      set_conv(1'b1);
      check("R4 narrow rise ignored", 32'(sl), 32'h30001);
      check("R4 narrow rise no pulse", 32'(vcount - c0), 32'd0);
      send_word(16, 18'h08001, 18'h07FFE);
      set_conv(1'b0);
      check("R3 narrow negative left", 32'(sl), 32'h38001);
      check("R3 narrow positive right", 32'(sr), 32'h07FFE);
      check("R7 narrow pulse", 32'(vcount - c0), 32'd1);
   endtask

   task automatic t_hold;
      int c0;
      c0 = vcount;
      send_word(7, 18'h0002A, 18'h00055);
      check("R8 hold left", 32'(sl), 32'h38001);
      check("R8 hold right", 32'(sr), 32'h07FFE);
      check("R8 no pulse", 32'(vcount - c0), 32'd0);
      set_conv(1'b1);
      send_word(16, 18'h01234, 18'h0F00F);
      set_conv(1'b0);
      check("R3 R6 second narrow left", 32'(sl), 32'h01234);
      check("R3 R6 second narrow right", 32'(sr), 32'h3F00F);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_wide();
      t_lead();
      t_narrow();
      t_hold();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule